// File: doc/BRIEF.md
# Accumulator ALU with N/Z/C/V flags

This block is the arithmetic and logic stage of a small accumulator processor. Each cycle the sequencer may present an operation code together with the accumulator, the X and Y index registers, an operand byte and the incoming N, V, Z and C flags. When the execute strobe is high, the block computes the operation and registers four things on the next rising clock edge:

- the result byte;
- a memory write-back byte;
- a destination mask saying which of A, X and memory take the new value;
- the updated flags.

Besides the usual add, subtract, logic, shift, rotate, compare, increment and decrement operations, the block implements fused operations. Some of these apply a read-modify-write step to the operand and then feed the modified byte into an accumulator operation. Others AND the accumulator with the operand before shifting, rotating or subtracting. Each has its own flag rule. Operand fetch, addressing, the bus and sequencing are done elsewhere. The decimal flag input has no effect.

Top module: `alu_acc8`

## Requirements
- R1: Code 1 adds: {C,result} = A + M + C_in, with V = 1 when A and M have the same sign bit and the result's sign bit differs. Code 2 subtracts the same way using ~M in place of M. Both write A (dest 3'b001).
- R2: Codes 3, 4 and 5 write A AND M, A OR M and A XOR M to A. N and Z come from the result, and C and V pass through unchanged from flags_i.
- R3: Codes 6 (shift left), 7 (shift right), 8 (rotate left) and 9 (rotate right) act on M and write memory (dest 3'b100, mem_o = result_o). Left moves take old bit 7 into C, and right moves take old bit 0 into C. Rotates fill the vacated bit with C_in, and shifts fill it with 0.
- R4: Codes 10, 11 and 12 compare A, X or Y with M. C = (reg >= M) unsigned, result_o = reg - M, N and Z come from that difference, and dest is 3'b000.
- R5: Codes 13 and 14 write M+1 and M-1 to memory. Codes 15 and 16 write X+1 and X-1 to X. N and Z come from the new value, and C and V are unchanged.
- R6: Code 17 computes T = A AND M and writes T>>1 to A with C = T bit 0. Code 19 writes T to A with C = T bit 7. N and Z come from the value written.
- R7: Code 18 writes {C_in, T[7:1]} to A, where T = A AND M. It sets C = T bit 0, and V = signed overflow of T + M. N and Z come from the written value.
- R8: Code 20 writes (A AND X) - M to X with no borrow in. It sets C = (A >= M) unsigned, and N and Z come from the new X.
- R9: Codes 21 to 24 modify M, put the modified byte on mem_o, and write to A the modified byte combined with A (dest 3'b101). The four variants are:
  - 21: shift left, then OR.
  - 22: shift right, then XOR.
  - 23: rotate left, then AND.
  - 24: rotate right, then add. The add takes the bit rotated out as its carry in, and C and V come from the add.
  For 21 to 23, C is the bit shifted or rotated out. N and Z come from the new A.
- R10: Code 25 writes M+1 to memory and A - (M+1) - !C_in to A (dest 3'b101), with C, V, N and Z as in the subtract. Code 26 writes M-1 to memory (dest 3'b100) and compares A with it: C = A >= M-1, and N and Z come from A - (M-1).
- R11: Code 27 writes M to both A and X (dest 3'b011), with N and Z from M. Codes 0 and 28 to 31 write nothing and pass all flags through.
- R12: The decimal-mode input has no effect on any output.
- R13: flags_o is {N,V,Z,C} in bits 3..0, and dest_o bits 0, 1 and 2 select A, X and memory. Outputs change on the clock edge after exec_i is high. In a cycle without exec_i, dest_o registers 3'b000 and the other outputs hold. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe |
| op_i | input | 5 | Operation code |
| acc_i | input | W | Accumulator |
| x_i | input | W | X index |
| y_i | input | W | Y index |
| opnd_i | input | W | Operand byte M |
| flags_i | input | 4 | Incoming {N,V,Z,C} |
| dec_i | input | 1 | Decimal-mode flag, ignored |
| result_o | output | W | Registered result for A or X |
| mem_o | output | W | Registered memory write-back byte, zero when memory is not a target |
| dest_o | output | 3 | Registered destination mask {MEM,X,A} |
| flags_o | output | 4 | Registered {N,V,Z,C} |

## Verification
The bench builds the block with its default data width W = 8. At that width, random operands land on sign-bit boundaries, carry-out at 0xFF and equal-compare cases often enough to exercise every code's flag rule. Random runs cover all 32 codes, including the unused ones, with the decimal input toggled at random. Directed cases cover:
- signed overflow on add;
- borrow on subtract;
- equal and unequal compares;
- the fused rotate-add and masked subtract;
- the hold behaviour when exec_i is low.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP = 5'd0,  OP_ADC = 5'd1,  OP_SBC = 5'd2,  OP_AND = 5'd3,
    OP_ORA = 5'd4,  OP_EOR = 5'd5,  OP_ASL = 5'd6,  OP_LSR = 5'd7,
    OP_ROL = 5'd8,  OP_ROR = 5'd9,  OP_CPA = 5'd10, OP_CPX = 5'd11,
    OP_CPY = 5'd12, OP_INM = 5'd13, OP_DEM = 5'd14, OP_INX = 5'd15,
    OP_DEX = 5'd16, OP_ASR = 5'd17, OP_ARO = 5'd18, OP_AC7 = 5'd19,
    OP_MSX = 5'd20, OP_SLO = 5'd21, OP_SRX = 5'd22, OP_RLN = 5'd23,
    OP_RRD = 5'd24, OP_ISB = 5'd25, OP_DCM = 5'd26, OP_LDAX = 5'd27
  } alu_op_e;

  localparam logic [2:0] DST_NONE = 3'b000;
  localparam logic [2:0] DST_A    = 3'b001;
  localparam logic [2:0] DST_X    = 3'b010;
  localparam logic [2:0] DST_M    = 3'b100;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] din_i,
  input  logic         left_i,
  input  logic         rot_i,
  input  logic         cin_i,
  output logic [W-1:0] dout_o,
  output logic         cout_o
);
  logic fill;
  assign fill = rot_i & cin_i;

  always_comb begin
    if (left_i) begin
      dout_o = {din_i[W-2:0], fill};
      cout_o = din_i[W-1];
    end else begin
      dout_o = {fill, din_i[W-1:1]};
      cout_o = din_i[0];
    end
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] m_i,
  input  alu_flags_t   fl_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] mem_o,
  output logic [2:0]   dest_o,
  output alu_flags_t   fl_o
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [W-1:0] t_am, t_ax, m_inc, m_dec, x_inc, x_dec;
  assign t_am  = a_i & m_i;
  assign t_ax  = a_i & x_i;
  assign m_inc = m_i + ONE;
  assign m_dec = m_i - ONE;
  assign x_inc = x_i + ONE;
  assign x_dec = x_i - ONE;

  // shifter operand selection
  logic [W-1:0] sh_in, sh_out;
  logic         sh_left, sh_rot, sh_cout;

  always_comb begin
    sh_in   = m_i;
    sh_left = 1'b0;
    sh_rot  = 1'b0;
    unique case (op)
      OP_ASL, OP_SLO: sh_left = 1'b1;
      OP_ROL, OP_RLN: begin sh_left = 1'b1; sh_rot = 1'b1; end
      OP_ROR, OP_RRD: sh_rot = 1'b1;
      OP_ASR:         sh_in = t_am;
      OP_ARO:         begin sh_in = t_am; sh_rot = 1'b1; end
      default: ;
    endcase
  end

  alu_shift #(.W(W)) u_shift (
    .din_i (sh_in),
    .left_i(sh_left),
    .rot_i (sh_rot),
    .cin_i (fl_i.c),
    .dout_o(sh_out),
    .cout_o(sh_cout)
  );

  // adder operand selection
  logic [W-1:0] ad_a, ad_b, ad_sum;
  logic         ad_cin, ad_cout, ad_ovf;

  always_comb begin
    ad_a   = a_i;
    ad_b   = m_i;
    ad_cin = fl_i.c;
    unique case (op)
      OP_SBC:         ad_b = ~m_i;
      OP_ARO:         begin ad_a = t_am; ad_cin = 1'b0; end
      OP_RRD:         begin ad_b = sh_out; ad_cin = sh_cout; end
      OP_ISB:         ad_b = ~m_inc;
      OP_CPA:         begin ad_b = ~m_i; ad_cin = 1'b1; end
      OP_CPX:         begin ad_a = x_i; ad_b = ~m_i; ad_cin = 1'b1; end
      OP_CPY:         begin ad_a = y_i; ad_b = ~m_i; ad_cin = 1'b1; end
      OP_DCM:         begin ad_b = ~m_dec; ad_cin = 1'b1; end
      OP_MSX:         begin ad_a = t_ax; ad_b = ~m_i; ad_cin = 1'b1; end
      default: ;
    endcase
  end

  alu_adder #(.W(W)) u_add (
    .a_i   (ad_a),
    .b_i   (ad_b),
    .cin_i (ad_cin),
    .sum_o (ad_sum),
    .cout_o(ad_cout),
    .ovf_o (ad_ovf)
  );

  // result, destination and flag update
  logic [W-1:0] nz_src;
  logic         upd_nz;

  always_comb begin
    res_o  = '0;
    mem_o  = '0;
    dest_o = DST_NONE;
    fl_o   = fl_i;
    upd_nz = 1'b1;
    nz_src = '0;
    unique case (op)
      OP_ADC, OP_SBC: begin
        res_o = ad_sum; dest_o = DST_A;
        fl_o.c = ad_cout; fl_o.v = ad_ovf;
      end
      OP_AND: begin res_o = t_am;        dest_o = DST_A; end
      OP_ORA: begin res_o = a_i | m_i;   dest_o = DST_A; end
      OP_EOR: begin res_o = a_i ^ m_i;   dest_o = DST_A; end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_o = sh_out; mem_o = sh_out; dest_o = DST_M;
        fl_o.c = sh_cout;
      end
      OP_CPA, OP_CPX, OP_CPY: begin
        res_o = ad_sum; fl_o.c = ad_cout;
      end
      OP_INM: begin res_o = m_inc; mem_o = m_inc; dest_o = DST_M; end
      OP_DEM: begin res_o = m_dec; mem_o = m_dec; dest_o = DST_M; end
      OP_INX: begin res_o = x_inc; dest_o = DST_X; end
      OP_DEX: begin res_o = x_dec; dest_o = DST_X; end
      OP_ASR: begin res_o = sh_out; dest_o = DST_A; fl_o.c = sh_cout; end
      OP_ARO: begin
        res_o = sh_out; dest_o = DST_A;
        fl_o.c = sh_cout; fl_o.v = ad_ovf;
      end
      OP_AC7: begin res_o = t_am; dest_o = DST_A; fl_o.c = t_am[MSB]; end
      OP_MSX: begin
        res_o = ad_sum; dest_o = DST_X;
        fl_o.c = (a_i >= m_i);
      end
      OP_SLO: begin
        res_o = a_i | sh_out; mem_o = sh_out; dest_o = DST_A | DST_M;
        fl_o.c = sh_cout;
      end
      OP_SRX: begin
        res_o = a_i ^ sh_out; mem_o = sh_out; dest_o = DST_A | DST_M;
        fl_o.c = sh_cout;
      end
      OP_RLN: begin
        res_o = a_i & sh_out; mem_o = sh_out; dest_o = DST_A | DST_M;
        fl_o.c = sh_cout;
      end
      OP_RRD: begin
        res_o = ad_sum; mem_o = sh_out; dest_o = DST_A | DST_M;
        fl_o.c = ad_cout; fl_o.v = ad_ovf;
      end
      OP_ISB: begin
        res_o = ad_sum; mem_o = m_inc; dest_o = DST_A | DST_M;
        fl_o.c = ad_cout; fl_o.v = ad_ovf;
      end
      OP_DCM: begin
        res_o = m_dec; mem_o = m_dec; dest_o = DST_M;
        fl_o.c = ad_cout;
      end
      OP_LDAX: begin res_o = m_i; dest_o = DST_A | DST_X; end
      default: upd_nz = 1'b0;
    endcase

    // compare-type ops take N/Z from the difference, not the written byte
    nz_src = (op == OP_DCM) ? ad_sum : res_o;
    if (upd_nz) begin
      fl_o.z = (nz_src == '0);
      fl_o.n = nz_src[MSB];
    end
  end

endmodule

// File: rtl/alu_acc8.sv
module alu_acc8
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         exec_i,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] opnd_i,
  input  logic [3:0]   flags_i,
  input  logic         dec_i,
  output logic [W-1:0] result_o,
  output logic [W-1:0] mem_o,
  output logic [2:0]   dest_o,
  output logic [3:0]   flags_o
);
  localparam int WE = W + 1;

  // decimal mode has no arithmetic effect
  logic unused_dec;
  assign unused_dec = dec_i;

  logic [W-1:0] res_n, mem_n;
  logic [2:0]   dest_n;
  alu_flags_t   fl_n;

  alu_core #(.W(W)) u_core (
    .op_i  (op_i),
    .a_i   (acc_i),
    .x_i   (x_i),
    .y_i   (y_i),
    .m_i   (opnd_i),
    .fl_i  (alu_flags_t'(flags_i)),
    .res_o (res_n),
    .mem_o (mem_n),
    .dest_o(dest_n),
    .fl_o  (fl_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      mem_o    <= '0;
      dest_o   <= '0;
      flags_o  <= '0;
    end else begin
      dest_o <= exec_i ? dest_n : 3'b000;
      if (exec_i) begin
        result_o <= res_n;
        mem_o    <= mem_n;
        flags_o  <= fl_n;
      end
    end
  end

  p_idle_dest_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!exec_i) |-> (dest_o == 3'b000));

  p_idle_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!exec_i) |-> ($stable(result_o) && $stable(flags_o) && $stable(mem_o)));

  p_no_x_and_mem_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dest_o[1] && dest_o[2]));

  p_add_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exec_i && (op_i == OP_ADC)) |->
      ({flags_o[0], result_o} ==
       $past({1'b0, acc_i} + {1'b0, opnd_i} + WE'(flags_i[0]))));

  p_logic_keeps_cv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exec_i && ((op_i == OP_AND) || (op_i == OP_ORA) || (op_i == OP_EOR))) |->
      ((flags_o[0] == $past(flags_i[0])) && (flags_o[2] == $past(flags_i[2]))));

  p_cmp_no_dest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exec_i && ((op_i == OP_CPA) || (op_i == OP_CPX) || (op_i == OP_CPY))) |->
      (dest_o == 3'b000));

  p_load_both_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exec_i && (op_i == OP_LDAX)) |->
      ((dest_o == 3'b011) && (result_o == $past(opnd_i))));

  p_masked_sub_x_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(exec_i && (op_i == OP_MSX)) |->
      ((dest_o == 3'b010) && (flags_o[0] == $past(acc_i >= opnd_i))));

endmodule

// File: tb/sim_alu_acc8.sv
module sim_alu_acc8;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 3000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic exec_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, x_i = '0, y_i = '0, opnd_i = '0;
  logic [3:0] flags_i = '0;
  logic dec_i = 1'b0;
  logic [7:0] result_o, mem_o;
  logic [2:0] dest_o;
  logic [3:0] flags_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_acc8 #(.W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .exec_i(exec_i), .op_i(op_i),
    .acc_i(acc_i), .x_i(x_i), .y_i(y_i), .opnd_i(opnd_i),
    .flags_i(flags_i), .dec_i(dec_i),
    .result_o(result_o), .mem_o(mem_o), .dest_o(dest_o), .flags_o(flags_o)
  );

  function automatic void model(
    input  logic [4:0] op, input logic [7:0] a, x, y, m, input logic [3:0] fi,
    output logic [7:0] r, output logic [7:0] mm, output logic [2:0] d,
    output logic [3:0] fo);
    logic n, v, z, c, nz;
    logic [8:0] s;
    logic [7:0] t, q, src;
    n = fi[3]; v = fi[2]; z = fi[1]; c = fi[0];
    r = '0; mm = '0; d = 3'b000; nz = 1'b1; src = '0;
    case (op)
      5'd1: begin s = {1'b0,a} + {1'b0,m} + {8'd0,c}; r = s[7:0]; d = 3'b001;
                  v = (a[7] == m[7]) && (r[7] != a[7]); c = s[8]; end
      5'd2: begin q = ~m; s = {1'b0,a} + {1'b0,q} + {8'd0,c}; r = s[7:0]; d = 3'b001;
                  v = (a[7] == q[7]) && (r[7] != a[7]); c = s[8]; end
      5'd3: begin r = a & m; d = 3'b001; end
      5'd4: begin r = a | m; d = 3'b001; end
      5'd5: begin r = a ^ m; d = 3'b001; end
      5'd6: begin r = {m[6:0], 1'b0}; c = m[7]; mm = r; d = 3'b100; end
      5'd7: begin r = {1'b0, m[7:1]}; c = m[0]; mm = r; d = 3'b100; end
      5'd8: begin r = {m[6:0], c}; c = m[7]; mm = r; d = 3'b100; end
      5'd9: begin r = {c, m[7:1]}; c = m[0]; mm = r; d = 3'b100; end
      5'd10: begin r = a - m; c = (a >= m); end
      5'd11: begin r = x - m; c = (x >= m); end
      5'd12: begin r = y - m; c = (y >= m); end
      5'd13: begin r = m + 8'd1; mm = r; d = 3'b100; end
      5'd14: begin r = m - 8'd1; mm = r; d = 3'b100; end
      5'd15: begin r = x + 8'd1; d = 3'b010; end
      5'd16: begin r = x - 8'd1; d = 3'b010; end
      5'd17: begin t = a & m; r = t >> 1; c = t[0]; d = 3'b001; end
      5'd18: begin t = a & m; r = {c, t[7:1]}; c = t[0]; d = 3'b001;
                   q = t + m; v = (t[7] == m[7]) && (q[7] != t[7]); end
      5'd19: begin r = a & m; c = r[7]; d = 3'b001; end
      5'd20: begin r = (a & x) - m; c = (a >= m); d = 3'b010; end
      5'd21: begin mm = {m[6:0], 1'b0}; c = m[7]; r = a | mm; d = 3'b101; end
      5'd22: begin mm = {1'b0, m[7:1]}; c = m[0]; r = a ^ mm; d = 3'b101; end
      5'd23: begin mm = {m[6:0], c}; c = m[7]; r = a & mm; d = 3'b101; end
      5'd24: begin mm = {c, m[7:1]};
                   s = {1'b0,a} + {1'b0,mm} + {8'd0,m[0]}; r = s[7:0]; c = s[8];
                   v = (a[7] == mm[7]) && (r[7] != a[7]); d = 3'b101; end
      5'd25: begin mm = m + 8'd1; q = ~mm;
                   s = {1'b0,a} + {1'b0,q} + {8'd0,c}; r = s[7:0]; c = s[8];
                   v = (a[7] == q[7]) && (r[7] != a[7]); d = 3'b101; end
      5'd26: begin r = m - 8'd1; mm = r; c = (a >= r); src = a - r; d = 3'b100; end
      5'd27: begin r = m; d = 3'b011; end
      default: nz = 1'b0;
    endcase
    if (op != 5'd26) src = r;
    if (nz) begin z = (src == 8'd0); n = src[7]; end
    fo = {n, v, z, c};
  endfunction

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd1, 5'd2: return "R1";
      5'd3, 5'd4, 5'd5: return "R2";
      5'd6, 5'd7, 5'd8, 5'd9: return "R3";
      5'd10, 5'd11, 5'd12: return "R4";
      5'd13, 5'd14, 5'd15, 5'd16: return "R5";
      5'd17, 5'd19: return "R6";
      5'd18: return "R7";
      5'd20: return "R8";
      5'd21, 5'd22, 5'd23, 5'd24: return "R9";
      5'd25, 5'd26: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] er, em,
                       input logic [2:0] ed, input logic [3:0] ef);
    n_vec++;
    if (result_o !== er || mem_o !== em || dest_o !== ed || flags_o !== ef) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h x=%h y=%h m=%h fi=%h: got res=%h mem=%h dest=%b fl=%b exp res=%h mem=%h dest=%b fl=%b",
               req, op_i, acc_i, x_i, y_i, opnd_i, flags_i,
               result_o, mem_o, dest_o, flags_o, er, em, ed, ef);
    end
  endtask

  // drive at negedge, check at following negedge
  task automatic apply(input string req, input logic [4:0] op, input logic [7:0] a, x, y, m,
                       input logic [3:0] fi, input logic dm);
    logic [7:0] er, em;
    logic [2:0] ed;
    logic [3:0] ef;
    op_i = op; acc_i = a; x_i = x; y_i = y; opnd_i = m; flags_i = fi;
    dec_i = dm; exec_i = 1'b1;
    model(op, a, x, y, m, fi, er, em, ed, ef);
    @(negedge clk);
    check(req, er, em, ed, ef);
  endtask

  initial begin
    logic [7:0] pr, pm;
    logic [3:0] pf;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    n_vec++;
    if (result_o !== 8'h00 || mem_o !== 8'h00 || dest_o !== 3'b000 || flags_o !== 4'h0) begin
      n_bad++;
      $display("FAIL R13 reset: res=%h mem=%h dest=%b fl=%b exp all zero",
               result_o, mem_o, dest_o, flags_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 signed overflow and carry corners
    apply("R1", 5'd1, 8'h50, 8'h00, 8'h00, 8'h50, 4'b0000, 1'b0);
    apply("R1", 5'd1, 8'hFF, 8'h00, 8'h00, 8'h00, 4'b0001, 1'b0);
    apply("R1", 5'd2, 8'h00, 8'h00, 8'h00, 8'h01, 4'b0001, 1'b0);
    apply("R1", 5'd2, 8'h80, 8'h00, 8'h00, 8'h01, 4'b0001, 1'b0);
    // R12 same add with decimal mode set
    apply("R12", 5'd1, 8'h19, 8'h00, 8'h00, 8'h28, 4'b0000, 1'b1);
    apply("R12", 5'd2, 8'h42, 8'h00, 8'h00, 8'h19, 4'b0001, 1'b1);
    // R2 OR keeps C,V and updates N/Z
    apply("R2", 5'd4, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0101, 1'b0);
    // R3 rotate through carry
    apply("R3", 5'd9, 8'h00, 8'h00, 8'h00, 8'h01, 4'b0001, 1'b0);
    // R4 equal and lower compare
    apply("R4", 5'd10, 8'h40, 8'h00, 8'h00, 8'h40, 4'b0000, 1'b0);
    apply("R4", 5'd12, 8'h00, 8'h00, 8'h10, 8'h11, 4'b0001, 1'b0);
    // R5 wrap
    apply("R5", 5'd13, 8'h00, 8'h00, 8'h00, 8'hFF, 4'b0000, 1'b0);
    apply("R5", 5'd16, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0000, 1'b0);
    // R6 / R7 / R8
    apply("R6", 5'd17, 8'hFF, 8'h00, 8'h00, 8'h03, 4'b0000, 1'b0);
    apply("R7", 5'd18, 8'hC0, 8'h00, 8'h00, 8'hC0, 4'b0001, 1'b0);
    apply("R8", 5'd20, 8'h0F, 8'hF3, 8'h00, 8'h05, 4'b0000, 1'b0);
    apply("R8", 5'd20, 8'h03, 8'hFF, 8'h00, 8'h04, 4'b0001, 1'b0);
    // R9 rotate right then add takes the rotated-out bit as carry
    apply("R9", 5'd24, 8'h10, 8'h00, 8'h00, 8'h03, 4'b0001, 1'b0);
    apply("R9", 5'd21, 8'h01, 8'h00, 8'h00, 8'h80, 4'b0000, 1'b0);
    // R10
    apply("R10", 5'd25, 8'h05, 8'h00, 8'h00, 8'h04, 4'b0001, 1'b0);
    apply("R10", 5'd26, 8'h07, 8'h00, 8'h00, 8'h08, 4'b0000, 1'b0);
    // R11 load both and unused code
    apply("R11", 5'd27, 8'h00, 8'h00, 8'h00, 8'h80, 4'b0000, 1'b0);
    apply("R11", 5'd30, 8'h12, 8'h34, 8'h56, 8'h78, 4'b1010, 1'b0);

    // R13 idle cycle: dest clears, data holds, new inputs ignored
    apply("R13", 5'd1, 8'h01, 8'h00, 8'h00, 8'h02, 4'b0000, 1'b0);
    pr = result_o; pm = mem_o; pf = flags_o;
    exec_i = 1'b0; op_i = 5'd2; acc_i = 8'hAA; opnd_i = 8'h55; flags_i = 4'hF;
    @(negedge clk);
    check("R13", pr, pm, 3'b000, pf);

    for (int i = 0; i < N_RAND; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 31));
      apply(req_of(op), op, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
            4'($urandom), 1'($urandom));
    end
    exec_i = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule